// File: doc/BRIEF.md
# Bidirectional Open-Drain Line Repeater

This block is the control logic of a repeater that joins a host-side line and a card-side line. Both lines rest high through passive pull-ups and are otherwise open-drain. The block watches sampled copies of both line levels. The first side to pull its line low becomes the master, and the block then copies that low onto the other side, the slave, by enabling a pull-down there. When the master lets its line go, the block releases the slave pull-down and fires a short active pull-up on the slave so that the rising edge is fast. After that both sides are left undriven again.

One lane handles one line pair. The top module builds a bank of identical lanes, three by default: one for the data line and two for auxiliary lines. The edge delay is a parameter counted in clock cycles. Each line input passes through a two-flop synchroniser before it is used. The analogue drive, the resistors and the voltage translation sit outside this block. The bench models each line as a wired-AND net.

Top module: `od_repeater_bank`

## Requirements
- R1: While reset is low, and on the first sampling point after it, all pull-down and pull-up enables of all lanes are 0. A reset taken in the middle of a transfer drops every enable after the next clock edge.
- R2: A falling edge on the host line of an idle lane makes the host the master. The card pull-down enable (card_pd_o) goes to 1 exactly EDGE_CYC+3 clock edges after the host line went low: two synchroniser stages, one edge register, then EDGE_CYC cycles of delay.
- R3: The same rule applies with the sides swapped. A falling edge on the card line of an idle lane leads to host_pd_o = 1 after EDGE_CYC+3 edges.
- R4: While a lane has a master, falling edges on the slave line are ignored. The master side's pull-down and pull-up enables stay 0 for the whole transfer, even if the slave device also pulls its line low.
- R5: The slave pull-down stays on until the synchronised master level is high again. It turns off three clock edges after the master line rises, so a master held low for L cycles with L > EDGE_CYC gives L-EDGE_CYC cycles of slave pull-down.
- R6: In the cycle after the slave pull-down turns off, the slave pull-up enable turns on. It stays on for exactly EDGE_CYC cycles, and then the lane is idle with no enable set.
- R7: If the master line returns high before the delay expires (held low for L ≤ EDGE_CYC cycles), the lane returns to idle and drives neither side at any time.
- R8: On each side of each lane, the pull-down and pull-up enables are never 1 in the same cycle.
- R9: If both lines of an idle lane show a falling edge in the same cycle, the host side wins and the card side is driven as slave.
- R10: Lanes are independent. Activity on one lane never sets an enable on another lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_line_i | input | LANES | Sampled level of each host-side line |
| card_line_i | input | LANES | Sampled level of each card-side line |
| host_pd_o | output | LANES | Pull-down enable for each host-side line |
| host_pu_o | output | LANES | Active pull-up enable for each host-side line |
| card_pd_o | output | LANES | Pull-down enable for each card-side line |
| card_pu_o | output | LANES | Active pull-up enable for each card-side line |

## Verification
Two pairs of events can land in the same cycle. The first pair is the two falling edges of an idle lane. The bench pulls both lines low on the same clock phase and then requires that only the card side is driven. The second pair is the master's release and the expiry of the slave delay. The bench holds the master low for exactly EDGE_CYC cycles, where the release must win and nothing is driven. It then holds it for EDGE_CYC+1 cycles, where exactly one cycle of slave pull-down must appear, followed by the full pull-up pulse.

// File: rtl/rep_pkg.sv
// Shared types for the line repeater.
// Assumes: nothing beyond the IEEE 1800-2017 type system.
package rep_pkg;

    // Phase of one lane's transfer.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WAIT  = 2'd1,
        PH_HOLD  = 2'd2,
        PH_BOOST = 2'd3
    } phase_t;

    // The side that owns the current transfer.
    typedef enum logic {
        SIDE_HOST = 1'b0,
        SIDE_CARD = 1'b1
    } side_t;

endpackage

// File: rtl/rep_sync2.sv
// Two-stage synchroniser for a vector of line levels.
// Assumes: lines idle high, so both stages reset to all ones.
module rep_sync2 #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta;

    // Shift the raw levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '1;
            q_o  <= '1;
        end else begin
            meta <= d_i;
            q_o  <= meta;
        end
    end

endmodule

// File: rtl/rep_lane.sv
// One repeater lane: first-falling-edge arbitration, delayed slave
// pull-down, and a timed active pull-up on release.
// Assumes: inputs are already synchronised; EDGE_CYC >= 3, so that the
// slave's synchronised level is high again before the lane goes idle.
module rep_lane
    import rep_pkg::*;
#(
    parameter int EDGE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_lvl,
    input  logic card_lvl,
    output logic host_pd,
    output logic host_pu,
    output logic card_pd,
    output logic card_pu
);

    localparam int             CW   = $clog2(EDGE_CYC) + 1;
    localparam logic [CW-1:0]  LAST = CW'(EDGE_CYC - 1);

    phase_t        phase_q, phase_d;
    side_t         owner_q, owner_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          host_prev, card_prev;
    logic          fall_h, fall_c, m_lvl;

    // Register the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_prev <= 1'b1;
            card_prev <= 1'b1;
        end else begin
            host_prev <= host_lvl;
            card_prev <= card_lvl;
        end
    end

    assign fall_h = host_prev & ~host_lvl;
    assign fall_c = card_prev & ~card_lvl;
    assign m_lvl  = (owner_q == SIDE_HOST) ? host_lvl : card_lvl;

    // Next-state logic; edges count only in idle (anti-latch lockout).
    always_comb begin
        phase_d = phase_q;
        owner_d = owner_q;
        cnt_d   = cnt_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (fall_h) begin
                    phase_d = PH_WAIT;
                    owner_d = SIDE_HOST;
                    cnt_d   = '0;
                end else if (fall_c) begin
                    phase_d = PH_WAIT;
                    owner_d = SIDE_CARD;
                    cnt_d   = '0;
                end
            end
            PH_WAIT: begin
                if (m_lvl) begin
                    phase_d = PH_IDLE;
                end else if (cnt_q == LAST) begin
                    phase_d = PH_HOLD;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PH_HOLD: begin
                if (m_lvl) begin
                    phase_d = PH_BOOST;
                    cnt_d   = '0;
                end
            end
            PH_BOOST: begin
                if (cnt_q == LAST) begin
                    phase_d = PH_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Hold the phase, owner and delay counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            owner_q <= SIDE_HOST;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            owner_q <= owner_d;
            cnt_q   <= cnt_d;
        end
    end

    // Decode the enables for the slave side only.
    always_comb begin
        host_pd = (phase_q == PH_HOLD)  && (owner_q == SIDE_CARD);
        host_pu = (phase_q == PH_BOOST) && (owner_q == SIDE_CARD);
        card_pd = (phase_q == PH_HOLD)  && (owner_q == SIDE_HOST);
        card_pu = (phase_q == PH_BOOST) && (owner_q == SIDE_HOST);
    end

    AST_PD_PU_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_pd && host_pu) && !(card_pd && card_pu)); // R8
    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !((host_pd || host_pu) && (card_pd || card_pu))); // R4
    AST_CARD_PD_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_pd) |-> !$past(host_lvl)); // R7
    AST_HOST_PD_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_pd) |-> !$past(card_lvl)); // R7
    AST_CARD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        card_pd && host_lvl |=> !card_pd && card_pu); // R6
    AST_HOST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        host_pd && card_lvl |=> !host_pd && host_pu); // R5

endmodule

// File: rtl/od_repeater_bank.sv
// Bank of identical line-repeater lanes with input synchronisers.
// Assumes: line inputs are asynchronous and idle high.
module od_repeater_bank #(
    parameter int LANES    = 3,
    parameter int EDGE_CYC = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] host_line_i,
    input  logic [LANES-1:0] card_line_i,
    output logic [LANES-1:0] host_pd_o,
    output logic [LANES-1:0] host_pu_o,
    output logic [LANES-1:0] card_pd_o,
    output logic [LANES-1:0] card_pu_o
);

    logic [LANES-1:0] host_s, card_s;

    rep_sync2 #(.W(LANES)) i_host_sync (
        .clk(clk), .rst_n(rst_n), .d_i(host_line_i), .q_o(host_s)
    );

    rep_sync2 #(.W(LANES)) i_card_sync (
        .clk(clk), .rst_n(rst_n), .d_i(card_line_i), .q_o(card_s)
    );

    // One independent lane per line pair (R10).
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rep_lane #(.EDGE_CYC(EDGE_CYC)) i_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .host_lvl (host_s[g]),
            .card_lvl (card_s[g]),
            .host_pd  (host_pd_o[g]),
            .host_pu  (host_pu_o[g]),
            .card_pd  (card_pd_o[g]),
            .card_pu  (card_pu_o[g])
        );
    end

endmodule

// File: tb/test_od_repeater_bank.sv
module test_od_repeater_bank;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 3;
    localparam int EDGE       = 4;
    localparam int NROW       = 8;
    // Columns: lane, side (0 host, 1 card, 2 both), low cycles,
    // slave-device low start (0 none), expected pd cycles, expected pu cycles.
    localparam int TV [NROW][6] = '{
        '{0, 0, 10, 0,  6, 4},
        '{1, 1,  7, 0,  3, 4},
        '{2, 0,  5, 0,  1, 4},
        '{0, 1,  4, 0,  0, 0},
        '{1, 0,  2, 0,  0, 0},
        '{2, 2,  9, 0,  5, 4},
        '{0, 0, 12, 5,  8, 4},
        '{1, 1, 20, 0, 16, 4}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LANES-1:0] host_ext = '0;
    logic [LANES-1:0] card_ext = '0;
    logic [LANES-1:0] host_line, card_line;
    logic [LANES-1:0] host_pd, host_pu, card_pd, card_pu;
    int total = 0;
    int bad = 0;

    assign host_line = ~host_ext & ~host_pd;
    assign card_line = ~card_ext & ~card_pd;

    always #(CLK_PERIOD/2) clk = ~clk;

    od_repeater_bank #(.LANES(LANES), .EDGE_CYC(EDGE)) i_od_repeater_bank (
        .clk(clk), .rst_n(rst_n),
        .host_line_i(host_line), .card_line_i(card_line),
        .host_pd_o(host_pd), .host_pu_o(host_pu),
        .card_pd_o(card_pd), .card_pu_o(card_pu)
    );

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_row(input int ln, input int sd, input int low,
                           input int sfrom, input int epd, input int epu);
        int first_pd = -1, last_pd = -1, first_pu = -1;
        int pdc = 0, puc = 0, ovl = 0, wrong = 0, other = 0;
        string tg;
        logic [LANES-1:0] mask;
        tg = (sd == 1) ? "R3" : ((sd == 2) ? "R9" : "R2");
        mask = ~(LANES'(1) << ln);
        @(negedge clk);
        if (sd != 1) host_ext[ln] = 1'b1;
        if (sd != 0) card_ext[ln] = 1'b1;
        for (int k = 1; k <= low + EDGE + 8; k++) begin
            logic spd, spu, mdrv;
            @(negedge clk);
            spd  = (sd == 1) ? host_pd[ln] : card_pd[ln];
            spu  = (sd == 1) ? host_pu[ln] : card_pu[ln];
            mdrv = (sd == 1) ? (card_pd[ln] | card_pu[ln]) : (host_pd[ln] | host_pu[ln]);
            if (spd) begin
                if (first_pd < 0) first_pd = k;
                last_pd = k;
                pdc++;
            end
            if (spu) begin
                if (first_pu < 0) first_pu = k;
                puc++;
            end
            if ((host_pd[ln] & host_pu[ln]) | (card_pd[ln] & card_pu[ln])) ovl++;
            if (mdrv) wrong++;
            if (|((host_pd | host_pu | card_pd | card_pu) & mask)) other++;
            if (k == low) begin
                host_ext[ln] = 1'b0;
                card_ext[ln] = 1'b0;
            end
            if (sfrom > 0 && k == sfrom) begin
                if (sd == 1) host_ext[ln] = 1'b1; else card_ext[ln] = 1'b1;
            end
            if (sfrom > 0 && k == sfrom + 4) begin
                if (sd == 1) host_ext[ln] = 1'b0; else card_ext[ln] = 1'b0;
            end
        end
        check(tg, "slave pd first cycle", first_pd, (epd > 0) ? EDGE + 3 : -1);
        check((epd == 0) ? "R7" : "R5", "slave pd cycles", pdc, epd);
        check((epu == 0) ? "R7" : "R6", "slave pu cycles", puc, epu);
        if (epu > 0) check("R6", "pu start after pd", first_pu, last_pd + 1);
        check("R8", "pd/pu overlap", ovl, 0);
        check("R4", "master side driven", wrong, 0);
        check("R10", "other lane active", other, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: enables are low during reset
        check("R1", "pd during reset", int'(host_pd | card_pd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "host_pd after reset", int'(host_pd), 0);
        check("R1", "host_pu after reset", int'(host_pu), 0);
        check("R1", "card_pd after reset", int'(card_pd), 0);
        check("R1", "card_pu after reset", int'(card_pu), 0);
        repeat (2) @(negedge clk);

        for (int r = 0; r < NROW; r++) begin
            run_row(TV[r][0], TV[r][1], TV[r][2], TV[r][3], TV[r][4], TV[r][5]);
            repeat (3) @(negedge clk);
        end

        // R1: reset in the middle of a hold drops the enables
        host_ext[2] = 1'b1;
        repeat (EDGE + 5) @(negedge clk);
        check("R2", "card_pd before mid reset", int'(card_pd[2]), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "card_pd after mid reset", int'(card_pd[2]), 0);
        host_ext[2] = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R1", "all enables idle after reset", int'(host_pd | host_pu | card_pd | card_pu), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule